// File: doc/BRIEF.md
# Modem Line Control and Status Register Block

This block holds the two modem-facing registers of an asynchronous serial controller. The control register is written by the host. Its low four bits drive four active-low handshake outputs: data-terminal-ready, request-to-send and two general-purpose outputs. A fifth bit selects a diagnostic loopback mode.

The status register reports four modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. These inputs are active-low pins. Each one passes through a multi-flop synchronizer, and the register reports it as asserted-high levels. Next to each level sits a sticky change flag, which is cleared by a host read of the status register. The ring line's flag records only the end of a ring.

When the modem-status interrupt is enabled, any set flag raises an interrupt request. In loopback mode the four outputs are held inactive, and the control bits are routed back as the status inputs instead of the pins.

Top module: `mdm_ctl_status`

## Requirements
- R1: After reset, all four outputs `dtr_n`, `rts_n`, `out1_n` and `out2_n` are high, `irq` is low, and both registers read 0x00 while the pins are inactive (high).
- R2: Writing the control register (`reg_sel`=0) sets the output pins as follows:
  - bit 0 drives `dtr_n`, bit 1 drives `rts_n`, bit 2 drives `out1_n` and bit 3 drives `out2_n`.
  - A 1 in a bit drives its pin low.
  - The control register reads back bits 4:0 as written; bits 7:5 read 0.
- R3: While control bit 4 (loopback) is 1, all four outputs are high, whatever bits 3:0 hold. Clearing bit 4 restores the outputs.
- R4: Status bits 4, 5, 6 and 7 report CTS, DSR, RI and DCD as 1 when the pin is low. A pin change reaches the level bit at the second rising edge after it is applied. It reaches the change flag at the third.
- R5: Status bits 0, 1 and 3 set on any change, in either direction, of CTS, DSR and DCD respectively. They stay set until the status register is read.
- R6: Status bit 2 sets only when the RI level bit goes from 1 to 0 (the `ri_n` pin rises). Its other transition leaves bit 2 clear.
- R7: A status read (`rd_en` with `reg_sel`=1) clears bits 3:0 at that clock edge. A change detected at the same edge is kept set.
- R8: `irq` is high exactly when `msi_en` is 1 and any of status bits 3:0 is set.
- R9: In loopback mode the status inputs come from the control bits and the pins are ignored:
  - CTS follows bit 1 (RTS).
  - DSR follows bit 0 (DTR).
  - RI follows bit 2 (OUT1).
  - DCD follows bit 3 (OUT2).
- R10: A write with `reg_sel`=1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The pins are toggled one at a time, and both edge directions are applied to each line. This separates the any-edge flags from the ring flag, which responds to one edge only. A read placed on the exact cycle a flag sets shows whether a clear racing a set keeps the event.

The outputs are driven with mixed bit patterns, so that each control bit is checked against its own pin. In loopback, the control bits are changed while a pin is driven to the opposite state. This shows that the status side follows the control bits and not the pins.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // Line order shared by the status levels, the change flags and the loopback map.
   localparam int LINE_CTS = 0;
   localparam int LINE_DSR = 1;
   localparam int LINE_RI  = 2;
   localparam int LINE_DCD = 3;
   localparam int NUM_LINES = 4;

   // Control register bit positions.
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;
   localparam int CTRL_BITS = 5;

   typedef logic [NUM_LINES-1:0] line_vec_t;

   // Loopback routing: each status line is fed by one control bit.
   function automatic line_vec_t loop_map(input logic [CTRL_BITS-1:0] c);
      line_vec_t v;
      v[LINE_CTS] = c[CB_RTS];
      v[LINE_DSR] = c[CB_DTR];
      v[LINE_RI]  = c[CB_OUT1];
      v[LINE_DCD] = c[CB_OUT2];
      return v;
   endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int WIDTH   = 4,
   parameter int STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[0] <= RST_VAL;
      else     chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
   import mdm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              loop_on,
   output logic [3:0]        pins_n
);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << CTRL_BITS) - 1);

   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_width
         $error("mdm_ctrl_reg: DATA_W too narrow for the control bits");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata & KEEP_MASK;
   end

   assign loop_on = ctrl_q[CB_LOOP];

   logic [3:0] drive_n;
   always_comb begin
      drive_n[0] = ~(ctrl_q[CB_DTR]  & ~loop_on);
      drive_n[1] = ~(ctrl_q[CB_RTS]  & ~loop_on);
      drive_n[2] = ~(ctrl_q[CB_OUT1] & ~loop_on);
      drive_n[3] = ~(ctrl_q[CB_OUT2] & ~loop_on);
   end

   generate
      if (OUT_REG) begin : g_out_ff
         always_ff @(posedge clk or posedge rst) begin
            if (rst) pins_n <= '1;
            else     pins_n <= drive_n;
         end
      end else begin : g_out_comb
         assign pins_n = drive_n;
      end
   endgenerate

   // R3: no output is asserted while loopback is selected (combinational variant)
   p_loop_idle_r3: assert property (@(posedge clk) disable iff (rst)
      (loop_on && !OUT_REG) |-> (pins_n == 4'hF));

   // R10: the register only moves on a control write
   p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
   import mdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  line_vec_t level,
   input  logic      rd_clr,
   output line_vec_t delta,
   output line_vec_t level_q
);
   line_vec_t prev;
   line_vec_t hit;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         if (i == LINE_RI) begin : g_trail
            assign hit[i] = prev[i] & ~level[i];
         end else begin : g_any
            assign hit[i] = prev[i] ^ level[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev  <= '0;
         delta <= '0;
      end else begin
         prev  <= level;
         delta <= (rd_clr ? '0 : delta) | hit;
      end
   end

   assign level_q = level;

   // R5: a flag stays set until a status read
   p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      !rd_clr |=> ((delta & $past(delta)) == $past(delta)));

   // R7: a read with no new change empties the flags
   p_clear_on_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && hit == '0) |=> (delta == '0));

   // R6: the ring flag rises only after a 1-to-0 step of the ring level
   p_ring_trailing_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(delta[LINE_RI]) |-> ($past(prev[LINE_RI]) && !$past(level[LINE_RI])));
endmodule

// File: rtl/mdm_ctl_status.sv
module mdm_ctl_status
   import mdm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              msi_en,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              out1_n,
   output logic              out2_n,
   output logic              irq
);
   localparam int STAT_BITS = 2 * NUM_LINES;

   generate
      if (DATA_W < STAT_BITS) begin : g_bad_width
         $error("mdm_ctl_status: DATA_W must hold the status byte");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic              loop_on;
   logic [3:0]        pins_n;

   mdm_ctrl_reg #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr_en && !reg_sel),
      .wdata  (wdata),
      .ctrl_q (ctrl_q),
      .loop_on(loop_on),
      .pins_n (pins_n)
   );

   assign dtr_n  = pins_n[0];
   assign rts_n  = pins_n[1];
   assign out1_n = pins_n[2];
   assign out2_n = pins_n[3];

   line_vec_t pin_raw_n, pin_sync_n, level_src, level_q, delta;

   always_comb begin
      pin_raw_n[LINE_CTS] = cts_n;
      pin_raw_n[LINE_DSR] = dsr_n;
      pin_raw_n[LINE_RI]  = ri_n;
      pin_raw_n[LINE_DCD] = dcd_n;
   end

   mdm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pin_raw_n),
      .q  (pin_sync_n)
   );

   assign level_src = loop_on ? loop_map(ctrl_q[CTRL_BITS-1:0]) : ~pin_sync_n;

   mdm_status_reg u_stat (
      .clk    (clk),
      .rst    (rst),
      .level  (level_src),
      .rd_clr (rd_en && reg_sel),
      .delta  (delta),
      .level_q(level_q)
   );

   assign rdata = reg_sel ? DATA_W'({level_q, delta}) : ctrl_q;
   assign irq   = msi_en && (delta != '0);

   // R8: a pending request always has an enable and a flag behind it
   p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
      irq |-> (msi_en && rdata_flags_any()));

   function automatic logic rdata_flags_any();
      return |delta;
   endfunction

   // R3: loopback keeps every output at its idle level one cycle after it is seen
   p_loop_pins_r3: assert property (@(posedge clk) disable iff (rst)
      (loop_on && $past(loop_on)) |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF));
endmodule

// File: tb/mdm_ctl_status_tb.sv
module mdm_ctl_status_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0, msi_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       dtr_n, rts_n, out1_n, out2_n, irq;

   int checks = 0;
   int fails  = 0;
   int        exp_q[$];
   string     tag_q[$];
   bit        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdm_ctl_status u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
      .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
      .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
      .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Driver: queues the expected read value, then issues a one-cycle read.
   task automatic rd(input bit sel, input int exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      reg_sel = sel;
      rd_en   = 1'b1;
      tick(1);
      rd_en   = 1'b0;
   endtask

   task automatic wr(input bit sel, input logic [7:0] v);
      reg_sel = sel;
      wdata   = v;
      wr_en   = 1'b1;
      tick(1);
      wr_en   = 1'b0;
   endtask

   // Monitor: compares each read against the queued expectation.
   always @(negedge clk) begin
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL monitor unexpected read actual=0x%0h expected=none", rdata);
         end else begin
            check(tag_q.pop_front(), int'(rdata), exp_q.pop_front());
         end
      end
   end

   function automatic int outs();
      return {28'd0, out2_n, out1_n, rts_n, dtr_n};
   endfunction

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      // R1: reset state
      check("R1 outputs", outs(), 'hF);
      check("R1 irq", int'(irq), 0);
      rd(0, 'h00, "R1 control read");
      rd(1, 'h00, "R1 status read");

      // R2: control bits drive pins low
      wr(0, 8'h0F);
      check("R2 all active", outs(), 'h0);
      wr(0, 8'h05);
      check("R2 pattern 05", outs(), 'hA);
      wr(0, 8'hEA);
      check("R2 pattern 0A", outs(), 'h5);
      rd(0, 'h0A, "R2 upper bits read zero");
      wr(0, 8'h05);

      // R4/R7/R8: CTS assert, latency and read racing a set
      msi_en = 1'b1;
      cts_n = 1'b0;
      tick(2);
      check("R8 irq before flag", int'(irq), 0);
      rd(1, 'h10, "R4 level after two flops, no flag yet");
      check("R8 irq with flag", int'(irq), 1);
      rd(1, 'h11, "R7 flag kept across racing read");
      check("R8 irq cleared by read", int'(irq), 0);
      rd(1, 'h10, "R7 flag cleared");

      // R5: DSR both directions
      dsr_n = 1'b0; tick(3);
      rd(1, 'h32, "R5 DSR assert flag");
      dsr_n = 1'b1; tick(3);
      rd(1, 'h12, "R5 DSR release flag");
      // R5: DCD both directions
      dcd_n = 1'b0; tick(3);
      rd(1, 'h98, "R5 DCD assert flag");
      dcd_n = 1'b1; tick(3);
      rd(1, 'h18, "R5 DCD release flag");

      // R6: ring flag only on pin rise
      ri_n = 1'b0; tick(3);
      check("R8 no irq without flag", int'(irq), 0);
      rd(1, 'h50, "R6 ring start sets no flag");
      ri_n = 1'b1; tick(3);
      rd(1, 'h14, "R6 ring end sets flag");

      // R8: disabled interrupt
      msi_en = 1'b0;
      cts_n = 1'b1; tick(3);
      check("R8 irq masked", int'(irq), 0);
      rd(1, 'h01, "R5 CTS release flag");
      msi_en = 1'b1;

      // R10: write to status address ignored
      wr(1, 8'hFF);
      rd(1, 'h00, "R10 status unchanged");
      rd(0, 'h05, "R10 control unchanged");
      check("R10 outputs unchanged", outs(), 'hA);

      // R3/R9: loopback
      wr(0, 8'h1F);
      check("R3 outputs idle in loop", outs(), 'hF);
      tick(1);
      rd(1, 'hFB, "R9 loop levels and flags");
      ri_n = 1'b0;
      wr(0, 8'h1B);
      check("R3 outputs idle in loop", outs(), 'hF);
      tick(3);
      rd(1, 'hB4, "R9 RI follows OUT1, pin ignored");
      wr(0, 8'h05);
      check("R3 outputs restored", outs(), 'hA);

      tick(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule